// File: doc/BRIEF.md
# Two-Thread Core Performance Event Counter Unit

This block gives one core of a two-thread processor a small set of performance counters. Two programmable counters each take their event from an event-select register. That register holds an event code, an 8-bit unit mask, a thread-merge flag and an enable. Three fixed counters always count the same things: retired instructions, active core cycles and reference-clock ticks. Each fixed counter has a two-bit field that says which threads it counts. Every counter is 40 bits wide and wraps modulo 2^40. On a wrap it sets a sticky overflow flag.

Two qualifier registers filter responses to requests that leave the core. An off-core response is counted only when the counter selects the response event code tied to that qualifier, and the response type shares a set bit with the qualifier. Average request latency is measured with two counters. One counts request issues. The other adds the number of outstanding requests on every clock.

Software uses a plain register port. A write takes effect on the next clock edge. A read returns the addressed register on `rd_data` one cycle after `reg_addr` is applied.

Top module: `pmu_core`

## Requirements
- R1: After reset every register reads zero, except the capability register at address 11. It reads 0x280302: bits [23:16] give the counter width (40), bits [15:8] the fixed counter count (3), and bits [7:0] the programmable counter count (2).
- R2: Register map. 0 and 1 are programmable counters 0 and 1. 2, 3 and 4 are fixed counters 0, 1 and 2. 5 and 6 are event-selects 0 and 1. 7 is fixed control. 8 is overflow status. 9 and 10 are qualifiers 0 and 1. 11 is capability. `rd_data` shows the register at `reg_addr` one clock after the address is presented.
- R3: Event-select layout: bits [7:0] are the code and [15:8] the unit mask. Code 0xC0 counts retired instructions and 0x3C counts active cycles. Code 0x2E counts a cycle when the thread's 8-bit sub-event vector ANDed with the unit mask is non-zero.
- R4: With bit 21 (merge) clear, only events of the thread on `own_tid` are counted. With bit 21 set, the counts of both threads are added.
- R5: While `thread_strict` is high, bit 21 is ignored and only the `own_tid` thread is counted.
- R6: Code 0xB7 counts valid responses whose type ANDed with qualifier 0 is non-zero. Code 0xBB does the same with qualifier 1. A zero qualifier counts nothing.
- R7: Code 0xB0 counts request issues. Code 0x60 adds the thread's 4-bit outstanding-request count on every clock, and both threads' counts when merging.
- R8: Bit 17 (precise sampling) is stored for event-select 0. For event-select 1 it is dropped and always reads 0.
- R9: With bit 22 (enable) clear, the counter holds its value but still accepts software writes.
- R10: Counters wrap modulo 2^40. On a wrap the counter sets its sticky bit in the overflow status register: bit 0 for counter 0, bit 1 for counter 1, bits 2 to 4 for fixed counters 0 to 2. Writing 1 to a bit clears it, and writing 0 leaves it.
- R11: Fixed control bits [2f+1:2f] enable fixed counter f for thread 1 and thread 0 (bit 2f is thread 0). Fixed counter 0 counts retired instructions. Fixed counter 1 counts active cycles. Fixed counter 2 counts active cycles that carry a reference tick. The enabled threads are summed.
- R12: If a software write and an increment hit the same counter in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_tid | input | 1 | Thread that owns the programmable counters |
| thread_strict | input | 1 | Ignore the merge flag when high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| inst_ret | input | 2 | Per-thread retired-instruction pulse |
| thr_active | input | 2 | Per-thread not-halted level |
| ref_tick | input | 1 | Reference clock tick |
| cache_ev | input | 16 | Per-thread 8-bit sub-event vector (thread 0 in [7:0]) |
| resp_vld | input | 2 | Per-thread off-core response valid |
| resp_type | input | 32 | Per-thread 16-bit response type (thread 0 in [15:0]) |
| req_issue | input | 2 | Per-thread off-core request issue pulse |
| occ_cnt | input | 8 | Per-thread 4-bit outstanding-request count (thread 0 in [3:0]) |

## Verification
A corrupted counter or a wrong per-thread merge shows up in the next read of that counter. That read comes one clock after the address is applied, so every event window is closed with a read and an exact arithmetic comparison. A lost or stuck overflow flag is visible in the status register right after the wrap cycle. A precise-sampling bit that leaks into event-select 1 appears in its next readback. The sweeps cover every combination of merge flag, strict mode, owner and thread pattern. They also cover every sub-event value against several unit masks, and one-hot response types against both qualifiers.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_GP   = 2;
  localparam int NUM_FX   = 3;
  localparam int SEL_W    = 32;
  localparam int UMASK_W  = 8;
  localparam int SEL_PREC = 17;
  localparam int SEL_ANY  = 21;
  localparam int SEL_EN   = 22;

  localparam logic [7:0] EV_INST  = 8'hC0;
  localparam logic [7:0] EV_CYC   = 8'h3C;
  localparam logic [7:0] EV_CACHE = 8'h2E;
  localparam logic [7:0] EV_RESPA = 8'hB7;
  localparam logic [7:0] EV_RESPB = 8'hBB;
  localparam logic [7:0] EV_REQ   = 8'hB0;
  localparam logic [7:0] EV_OCC   = 8'h60;

  localparam logic [3:0] AD_GP0   = 4'd0;
  localparam logic [3:0] AD_GP1   = 4'd1;
  localparam logic [3:0] AD_FX0   = 4'd2;
  localparam logic [3:0] AD_FX1   = 4'd3;
  localparam logic [3:0] AD_FX2   = 4'd4;
  localparam logic [3:0] AD_SEL0  = 4'd5;
  localparam logic [3:0] AD_SEL1  = 4'd6;
  localparam logic [3:0] AD_FXCTL = 4'd7;
  localparam logic [3:0] AD_OVF   = 4'd8;
  localparam logic [3:0] AD_QUAL0 = 4'd9;
  localparam logic [3:0] AD_QUAL1 = 4'd10;
  localparam logic [3:0] AD_CAP   = 4'd11;
endpackage

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
  import pmu_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int QUAL_W  = 16,
  parameter int OCC_W   = 4,
  parameter int TID_W   = 1,
  parameter int INC_W   = 5
) (
  input  logic [SEL_W-1:0]            sel,
  input  logic [TID_W-1:0]            own_tid,
  input  logic                        strict,
  input  logic [QUAL_W-1:0]           qual_a,
  input  logic [QUAL_W-1:0]           qual_b,
  input  logic [THREADS-1:0]          inst,
  input  logic [THREADS-1:0]          cyc,
  input  logic [THREADS-1:0]          req,
  input  logic [THREADS-1:0]          resp_vld,
  input  logic [THREADS*UMASK_W-1:0]  sub_ev,
  input  logic [THREADS*QUAL_W-1:0]   resp_type,
  input  logic [THREADS*OCC_W-1:0]    occ,
  output logic [INC_W-1:0]            inc
);
  logic [7:0]         code;
  logic [UMASK_W-1:0] umask;
  logic [OCC_W-1:0]   per_t [THREADS];

  assign code  = sel[7:0];
  assign umask = sel[8 +: UMASK_W];

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_comb begin
      case (code)
        EV_INST:  per_t[t] = OCC_W'(inst[t]);
        EV_CYC:   per_t[t] = OCC_W'(cyc[t]);
        EV_CACHE: per_t[t] = OCC_W'(|(sub_ev[t*UMASK_W +: UMASK_W] & umask));
        EV_RESPA: per_t[t] = OCC_W'(resp_vld[t] & |(resp_type[t*QUAL_W +: QUAL_W] & qual_a));
        EV_RESPB: per_t[t] = OCC_W'(resp_vld[t] & |(resp_type[t*QUAL_W +: QUAL_W] & qual_b));
        EV_REQ:   per_t[t] = OCC_W'(req[t]);
        EV_OCC:   per_t[t] = occ[t*OCC_W +: OCC_W];
        default:  per_t[t] = '0;
      endcase
    end
  end

  // Thread merge: the owner always counts, others only when merging is allowed.
  always_comb begin
    inc = '0;
    if (sel[SEL_EN]) begin
      for (int i = 0; i < THREADS; i++) begin
        if (TID_W'(i) == own_tid || (sel[SEL_ANY] && !strict))
          inc = inc + INC_W'(per_t[i]);
      end
    end
  end
endmodule

// File: rtl/pmu_ctr.sv
module pmu_ctr #(
  parameter int CNT_W = 40,
  parameter int INC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [INC_W-1:0] inc,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] q,
  output logic             ovf
);
  logic [CNT_W:0] sum;
  assign sum = {1'b0, q} + (CNT_W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      ovf <= 1'b0;
    end else begin
      q   <= wr ? wdata : sum[CNT_W-1:0];
      ovf <= (ovf & ~ovf_clr) | (~wr & sum[CNT_W]);
    end
  end

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (rst)
    wr |=> q == $past(wdata));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!wr && inc == '0) |=> $stable(q));
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/pmu_core.sv
module pmu_core
  import pmu_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int CNT_W   = 40,
  parameter int DATA_W  = 64,
  parameter int QUAL_W  = 16,
  parameter int OCC_W   = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [TID_W-1:0]           own_tid,
  input  logic                       thread_strict,
  input  logic                       reg_we,
  input  logic [3:0]                 reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          rd_data,
  input  logic [THREADS-1:0]         inst_ret,
  input  logic [THREADS-1:0]         thr_active,
  input  logic                       ref_tick,
  input  logic [THREADS*UMASK_W-1:0] cache_ev,
  input  logic [THREADS-1:0]         resp_vld,
  input  logic [THREADS*QUAL_W-1:0]  resp_type,
  input  logic [THREADS-1:0]         req_issue,
  input  logic [THREADS*OCC_W-1:0]   occ_cnt
);
  localparam int INC_W    = OCC_W + TID_W;
  localparam int FX_INC_W = TID_W + 1;
  localparam int FXCTL_W  = NUM_FX * THREADS;
  localparam int NUM_CTR  = NUM_GP + NUM_FX;
  localparam logic [SEL_W-1:0] PREC_BIT = SEL_W'(1) << SEL_PREC;

  logic [SEL_W-1:0]   sel_q [NUM_GP];
  logic [QUAL_W-1:0]  qual_q [2];
  logic [FXCTL_W-1:0] fxctl_q;
  logic [CNT_W-1:0]   gp_q [NUM_GP];
  logic [CNT_W-1:0]   fx_q [NUM_FX];
  logic [NUM_CTR-1:0] ovf;
  logic [NUM_CTR-1:0] ovf_clr;
  logic [THREADS-1:0] fx_src [NUM_FX];

  assign ovf_clr = (reg_we && reg_addr == AD_OVF) ? reg_wdata[NUM_CTR-1:0] : '0;

  // Configuration registers; precise sampling is kept only for counter 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q[0] <= '0;
      sel_q[1] <= '0;
      qual_q[0] <= '0;
      qual_q[1] <= '0;
      fxctl_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        AD_SEL0:  sel_q[0]  <= reg_wdata[SEL_W-1:0];
        AD_SEL1:  sel_q[1]  <= reg_wdata[SEL_W-1:0] & ~PREC_BIT;
        AD_QUAL0: qual_q[0] <= reg_wdata[QUAL_W-1:0];
        AD_QUAL1: qual_q[1] <= reg_wdata[QUAL_W-1:0];
        AD_FXCTL: fxctl_q   <= reg_wdata[FXCTL_W-1:0];
        default:  ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
    logic [INC_W-1:0] inc;
    logic             wr;
    assign wr = reg_we && (reg_addr == AD_GP0 + 4'(g));

    pmu_evt_filter #(
      .THREADS(THREADS), .QUAL_W(QUAL_W), .OCC_W(OCC_W), .TID_W(TID_W), .INC_W(INC_W)
    ) u_filt (
      .sel(sel_q[g]), .own_tid(own_tid), .strict(thread_strict),
      .qual_a(qual_q[0]), .qual_b(qual_q[1]),
      .inst(inst_ret), .cyc(thr_active), .req(req_issue), .resp_vld(resp_vld),
      .sub_ev(cache_ev), .resp_type(resp_type), .occ(occ_cnt), .inc(inc)
    );

    pmu_ctr #(.CNT_W(CNT_W), .INC_W(INC_W)) u_ctr (
      .clk(clk), .rst(rst), .wr(wr), .wdata(reg_wdata[CNT_W-1:0]), .inc(inc),
      .ovf_clr(ovf_clr[g]), .q(gp_q[g]), .ovf(ovf[g])
    );

    // Strict mode: an instruction count advances by the owner's pulse only.
    assert_strict_owner_R5: assert property (@(posedge clk) disable iff (rst)
      (thread_strict && !wr && sel_q[g][SEL_EN] && sel_q[g][7:0] == EV_INST)
        |=> gp_q[g] == $past(gp_q[g]) + CNT_W'($past(inst_ret[own_tid])));
  end

  assign fx_src[0] = inst_ret;
  assign fx_src[1] = thr_active;
  assign fx_src[2] = thr_active & {THREADS{ref_tick}};

  for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
    logic [FX_INC_W-1:0] inc;
    logic                wr;
    assign wr = reg_we && (reg_addr == AD_FX0 + 4'(f));

    always_comb begin
      inc = '0;
      for (int t = 0; t < THREADS; t++)
        inc = inc + FX_INC_W'(fxctl_q[f*THREADS + t] & fx_src[f][t]);
    end

    pmu_ctr #(.CNT_W(CNT_W), .INC_W(FX_INC_W)) u_ctr (
      .clk(clk), .rst(rst), .wr(wr), .wdata(reg_wdata[CNT_W-1:0]), .inc(inc),
      .ovf_clr(ovf_clr[NUM_GP+f]), .q(fx_q[f]), .ovf(ovf[NUM_GP+f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_addr)
        AD_GP0:   rd_data <= DATA_W'(gp_q[0]);
        AD_GP1:   rd_data <= DATA_W'(gp_q[1]);
        AD_FX0:   rd_data <= DATA_W'(fx_q[0]);
        AD_FX1:   rd_data <= DATA_W'(fx_q[1]);
        AD_FX2:   rd_data <= DATA_W'(fx_q[2]);
        AD_SEL0:  rd_data <= DATA_W'(sel_q[0]);
        AD_SEL1:  rd_data <= DATA_W'(sel_q[1]);
        AD_FXCTL: rd_data <= DATA_W'(fxctl_q);
        AD_OVF:   rd_data <= DATA_W'(ovf);
        AD_QUAL0: rd_data <= DATA_W'(qual_q[0]);
        AD_QUAL1: rd_data <= DATA_W'(qual_q[1]);
        AD_CAP:   rd_data <= DATA_W'({8'(CNT_W), 8'(NUM_FX), 8'(NUM_GP)});
        default:  rd_data <= '0;
      endcase
    end
  end

  assert_no_precise_ctr1_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == AD_SEL1) |-> !rd_data[SEL_PREC]);
endmodule

// File: tb/pmu_core_tb_top.sv
`timescale 1ns/1ps
module pmu_core_tb_top;
  localparam logic [3:0] A_GP0 = 0, A_GP1 = 1, A_FX0 = 2, A_FX1 = 3, A_FX2 = 4;
  localparam logic [3:0] A_SEL0 = 5, A_SEL1 = 6, A_FXCTL = 7, A_OVF = 8;
  localparam logic [3:0] A_Q0 = 9, A_Q1 = 10, A_CAP = 11;
  localparam longint WRAP = 64'd1 << 40;

  logic clk = 0, rst = 1;
  logic own_tid = 0, thread_strict = 0, reg_we = 0, ref_tick = 0;
  logic [3:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, rd_data;
  logic [1:0] inst_ret = 0, thr_active = 0, resp_vld = 0, req_issue = 0;
  logic [15:0] cache_ev = 0;
  logic [31:0] resp_type = 0;
  logic [7:0] occ_cnt = 0;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pmu_core dut_i (
    .clk(clk), .rst(rst), .own_tid(own_tid), .thread_strict(thread_strict),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .inst_ret(inst_ret), .thr_active(thr_active), .ref_tick(ref_tick),
    .cache_ev(cache_ev), .resp_vld(resp_vld), .resp_type(resp_type),
    .req_issue(req_issue), .occ_cnt(occ_cnt)
  );

  function automatic logic [63:0] mksel(logic [7:0] code, logic [7:0] um, bit en, bit any);
    return (64'(en) << 22) | (64'(any) << 21) | {48'd0, um, code};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [63:0] exp);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 / R2: reset values and capability field layout
    for (int a = 0; a < 11; a++) chk_reg("R1 reset", 4'(a), 64'd0);
    chk_reg("R1 R2 capability", A_CAP, 64'h280302);

    // R4 / R5: every merge flag, strict mode, owner and thread pattern
    for (int a = 0; a < 2; a++)
      for (int s = 0; s < 2; s++)
        for (int o = 0; o < 2; o++)
          for (int p = 0; p < 4; p++) begin
            longint exp;
            own_tid = o[0]; thread_strict = s[0];
            wr(A_SEL0, mksel(8'hC0, 8'h00, 1, a[0]));
            wr(A_GP0, 0);
            inst_ret = p[1:0];
            repeat (5) @(negedge clk);
            inst_ret = 0;
            exp = (a == 1 && s == 0) ? 5 * $countones(p[1:0]) : 5 * ((p >> o) & 1);
            chk_reg((a == 1 && s == 1) ? "R5 strict" : "R4 merge", A_GP0, 64'(exp));
          end
    own_tid = 0; thread_strict = 0;

    // R3: sub-event vector sweep against several unit masks; thread 1 noise
    for (int m = 0; m < 4; m++) begin
      logic [7:0] um;
      int exp;
      um = (m == 0) ? 8'h01 : (m == 1) ? 8'h05 : (m == 2) ? 8'hA0 : 8'hFF;
      wr(A_SEL0, mksel(8'h2E, um, 1, 0));
      wr(A_GP0, 0);
      exp = 0;
      for (int v = 0; v < 256; v++) begin
        cache_ev = {8'hFF, 8'(v)};
        if ((8'(v) & um) != 0) exp++;
        @(negedge clk);
      end
      cache_ev = 0;
      chk_reg("R3 unit mask", A_GP0, 64'(exp));
    end

    // R6: one-hot response types against both qualifiers
    begin
      int e0, e1;
      wr(A_Q0, 64'h00F0); wr(A_Q1, 64'h0F00);
      wr(A_SEL0, mksel(8'hB7, 0, 1, 0)); wr(A_SEL1, mksel(8'hBB, 0, 1, 0));
      wr(A_GP0, 0); wr(A_GP1, 0);
      e0 = 0; e1 = 0;
      for (int i = 0; i < 64; i++) begin
        logic [15:0] ty;
        ty = 16'(1) << (i % 16);
        resp_vld = {1'b1, i < 48};
        resp_type = {16'hFFFF, ty};
        if (i < 48 && (ty & 16'h00F0) != 0) e0++;
        if (i < 48 && (ty & 16'h0F00) != 0) e1++;
        @(negedge clk);
      end
      resp_vld = 0; resp_type = 0;
      chk_reg("R6 qualifier 0", A_GP0, 64'(e0));
      chk_reg("R6 qualifier 1", A_GP1, 64'(e1));
      wr(A_Q0, 0); wr(A_GP0, 0);
      resp_vld = 2'b01; resp_type = 32'h0000FFFF;
      repeat (6) @(negedge clk);
      resp_vld = 0; resp_type = 0;
      chk_reg("R6 zero qualifier", A_GP0, 64'd0);
    end

    // R7: request count and occupancy-weighted cycles
    begin
      int er, eo;
      wr(A_SEL0, mksel(8'hB0, 0, 1, 0)); wr(A_SEL1, mksel(8'h60, 0, 1, 0));
      wr(A_GP0, 0); wr(A_GP1, 0);
      er = 0; eo = 0;
      for (int i = 0; i < 40; i++) begin
        req_issue = {1'b1, (i % 3) == 0};
        occ_cnt = {4'd9, 4'(i % 16)};
        if (i % 3 == 0) er++;
        eo += i % 16;
        @(negedge clk);
      end
      req_issue = 0; occ_cnt = 0;
      chk_reg("R7 requests", A_GP0, 64'(er));
      chk_reg("R7 weighted cycles", A_GP1, 64'(eo));
      wr(A_SEL1, mksel(8'h60, 0, 1, 1)); wr(A_GP1, 0);
      occ_cnt = 8'hFF;
      repeat (10) @(negedge clk);
      occ_cnt = 0;
      chk_reg("R7 merged occupancy", A_GP1, 64'd300);
    end

    // R8: precise bit kept on select 0, dropped on select 1
    wr(A_SEL1, (64'd1 << 17) | mksel(8'hC0, 0, 1, 0));
    chk_reg("R8 select 1", A_SEL1, mksel(8'hC0, 0, 1, 0));
    wr(A_SEL0, (64'd1 << 17) | mksel(8'hC0, 0, 1, 0));
    chk_reg("R8 select 0", A_SEL0, (64'd1 << 17) | mksel(8'hC0, 0, 1, 0));

    // R9: disabled counter holds but takes writes
    wr(A_SEL0, mksel(8'hC0, 0, 0, 1));
    wr(A_GP0, 5);
    inst_ret = 2'b11; repeat (8) @(negedge clk); inst_ret = 0;
    chk_reg("R9 hold", A_GP0, 64'd5);
    wr(A_GP0, 77);
    chk_reg("R9 write while off", A_GP0, 64'd77);

    // R10: wrap, sticky flag, write-1-to-clear
    wr(A_OVF, 64'h1F);
    wr(A_SEL0, mksel(8'hC0, 0, 1, 0));
    wr(A_GP0, 64'(WRAP - 3));
    inst_ret = 2'b01; repeat (5) @(negedge clk); inst_ret = 0;
    chk_reg("R10 wrap value", A_GP0, 64'd2);
    chk_reg("R10 flag set", A_OVF, 64'h01);
    wr(A_OVF, 64'h1E);
    chk_reg("R10 zero bit keeps flag", A_OVF, 64'h01);
    wr(A_OVF, 64'h01);
    chk_reg("R10 flag cleared", A_OVF, 64'h00);
    wr(A_SEL1, mksel(8'h60, 0, 1, 0));
    wr(A_GP1, 64'(WRAP - 1));
    occ_cnt = 8'h0F; @(negedge clk); occ_cnt = 0;
    chk_reg("R10 weighted wrap", A_GP1, 64'd14);
    chk_reg("R10 flag 1", A_OVF, 64'h02);
    wr(A_OVF, 64'h02);

    // R11: fixed counters with per-thread enables
    begin
      int e0, e1, e2;
      wr(A_SEL0, 0); wr(A_SEL1, 0);
      wr(A_FXCTL, 64'h2D);
      e0 = 0; e1 = 0; e2 = 0;
      for (int i = 0; i < 32; i++) begin
        logic [4:0] b;
        b = 5'(i);
        inst_ret = b[1:0]; thr_active = b[3:2]; ref_tick = b[4];
        e0 += b[0];
        e1 += b[2] + b[3];
        e2 += b[3] & b[4];
        @(negedge clk);
      end
      inst_ret = 0; thr_active = 0; ref_tick = 0;
      chk_reg("R11 instructions", A_FX0, 64'(e0));
      chk_reg("R11 core cycles", A_FX1, 64'(e1));
      chk_reg("R11 reference cycles", A_FX2, 64'(e2));
      wr(A_FX1, 64'(WRAP - 1));
      thr_active = 2'b11; @(negedge clk); thr_active = 0;
      chk_reg("R11 R10 fixed wrap", A_FX1, 64'd1);
      chk_reg("R11 R10 fixed flag", A_OVF, 64'h08);
      wr(A_FXCTL, 0);
    end

    // R12: write and increment in the same cycle
    wr(A_SEL0, mksel(8'hC0, 0, 1, 0));
    wr(A_GP0, 0);
    @(negedge clk);
    inst_ret = 2'b01; reg_we = 1; reg_addr = A_GP0; reg_wdata = 100;
    @(negedge clk);
    reg_we = 0; inst_ret = 0;
    chk_reg("R12 write wins", A_GP0, 64'd100);
    inst_ret = 2'b01; repeat (3) @(negedge clk); inst_ret = 0;
    chk_reg("R12 counting resumes", A_GP0, 64'd103);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule